// File: doc/BRIEF.md
# Multi-Mode Timer Channel Start Sequencer

A single 16-bit timer channel that can run as an interval timer, an external-event counter, a free-running capture counter, a one-shot countdown, or a one-shot capture counter. Most of its logic governs what happens after software issues a start write. In most modes the start does not take effect at the write. The channel raises its enabled flag and then waits for a later count-clock enable tick or an external trigger. The first tick loads either the reload value or zero, and only the ticks after it count.

The channel runs on the system clock. A prescaler outside the block supplies the count clock as a one-cycle enable pulse. The external event input is a qualified one-cycle strobe. The external trigger input is a level, and the channel acts on its rising edge. The channel provides the counter value, the enabled flag, a captured counter value and a one-cycle interrupt pulse. The interrupt is registered, so it is high in the same cycle in which the counter shows the result of the edge that caused it.

Top module: `tmr_chan_start`

## Requirements
- R1: After reset, the counter and capture value are 0000h, and the enabled flag and interrupt are low.
- R2: The mode is captured from mode_sel on a start write: 0 is interval, 1 is event counter, 2 is capture, 3 is one-shot, 4 is one-shot capture, and codes 5 to 7 behave as interval. A start write sets the enabled flag at that clock edge. If start and stop are written in the same cycle, the stop wins.
- R3: In interval and capture modes, the counter keeps its previous value from the start write until the first tick.
- R4: In interval mode, the first tick after the start loads reload_val, and each later tick decrements the counter. A tick that finds 0000h reloads reload_val and raises the interrupt for one cycle.
- R5: In event counter mode, the start write loads reload_val at once. Each evt_in strobe decrements the counter, and a strobe that finds 0000h reloads the counter and pulses the interrupt. Count-clock ticks and trigger edges leave the counter unchanged.
- R6: In capture mode, the first tick loads 0000h, and each later tick increments the counter. A trigger rising edge copies the counter into cap_val, pulses the interrupt and sets the counter to 0000h. When a trigger edge and a tick arrive in the same cycle, the trigger wins.
- R7: In one-shot mode, a start write enters a wait-for-trigger state in which ticks have no effect. A trigger rising edge arms the channel. The first tick after that edge, not a tick in the same cycle, loads reload_val, and later ticks decrement the counter.
- R8: In one-shot mode, a tick that finds 0000h pulses the interrupt, leaves the counter at 0000h and returns the channel to waiting. Trigger edges that arrive while the counter is running are ignored.
- R9: In one-shot capture mode, the first tick after a trigger edge loads 0000h, and later ticks increment the counter. The next trigger edge copies the counter into cap_val, pulses the interrupt, holds the counter and returns the channel to waiting.
- R10: A stop write clears the enabled flag, cancels any pending start or armed trigger, and freezes the counter. Later ticks, events and triggers do not change it.
- R11: The trigger acts only on a rising edge. A trigger held high for several cycles counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count-clock enable pulse from the prescaler |
| start_wr | input | 1 | Start write strobe |
| stop_wr | input | 1 | Stop write strobe |
| mode_sel | input | 3 | Operating mode code, captured at a start write |
| reload_val | input | CNT_W | Reload value for the countdown modes |
| evt_in | input | 1 | Qualified external event strobe |
| trig_in | input | 1 | External trigger level; its rising edge is used |
| cnt_val | output | CNT_W | Current counter value |
| chan_en | output | 1 | Channel enabled flag |
| cap_val | output | CNT_W | Last captured counter value |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong sequencer state shows up at the ports as a counter that changes one tick too early or one tick too late after a start or trigger. It can also show up as a counter that moves in a mode where it should hold. These faults appear at the first count-clock tick after the stimulus, so the sweeps check the counter on every step around each start and trigger. Faults in the zero or reload decision show up as a misplaced interrupt or a wrong count within one reload period. The sweeps cover reload values down to zero so that the shortest periods are included.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [2:0] {
    MD_INTERVAL    = 3'd0,
    MD_EVENT       = 3'd1,
    MD_CAPTURE     = 3'd2,
    MD_ONESHOT     = 3'd3,
    MD_CAP_ONESHOT = 3'd4
  } tmr_mode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PEND,
    ST_RUN,
    ST_WAIT,
    ST_ARMED
  } tmr_state_e;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_LD_RLD,
    ACT_LD_ZERO,
    ACT_DEC,
    ACT_INC,
    ACT_CAP_ZERO,
    ACT_CAP_HOLD
  } tmr_act_e;

  function automatic tmr_mode_e mode_decode(input logic [2:0] code);
    case (code)
      3'd1:    return MD_EVENT;
      3'd2:    return MD_CAPTURE;
      3'd3:    return MD_ONESHOT;
      3'd4:    return MD_CAP_ONESHOT;
      default: return MD_INTERVAL;
    endcase
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign rise_o = sig_in & ~sig_q;
endmodule

// File: rtl/tmr_start_ctl.sv
module tmr_start_ctl
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_wr,
  input  logic       stop_wr,
  input  logic [2:0] mode_sel,
  input  logic       tick_en,
  input  logic       evt_in,
  input  logic       trig_rise,
  input  logic       cnt_zero,
  output tmr_act_e   act_o,
  output logic       irq_set_o,
  output logic       en_o
);
  tmr_state_e state_q, state_d;
  tmr_mode_e  mode_q, mode_d, mode_new;
  logic       en_q, en_d;

  assign mode_new = mode_decode(mode_sel);

  // next-state and action decode
  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    en_d      = en_q;
    act_o     = ACT_HOLD;
    irq_set_o = 1'b0;
    if (stop_wr) begin
      state_d = ST_OFF;
      en_d    = 1'b0;
    end else if (start_wr) begin
      en_d   = 1'b1;
      mode_d = mode_new;
      case (mode_new)
        MD_EVENT: begin
          act_o   = ACT_LD_RLD;
          state_d = ST_RUN;
        end
        MD_ONESHOT, MD_CAP_ONESHOT: state_d = ST_WAIT;
        default:                    state_d = ST_PEND;
      endcase
    end else begin
      case (state_q)
        ST_PEND: if (tick_en) begin
          act_o   = (mode_q == MD_INTERVAL) ? ACT_LD_RLD : ACT_LD_ZERO;
          state_d = ST_RUN;
        end
        ST_WAIT: if (trig_rise) state_d = ST_ARMED;
        ST_ARMED: if (tick_en) begin
          act_o   = (mode_q == MD_ONESHOT) ? ACT_LD_RLD : ACT_LD_ZERO;
          state_d = ST_RUN;
        end
        ST_RUN: begin
          case (mode_q)
            MD_INTERVAL: if (tick_en) begin
              act_o     = cnt_zero ? ACT_LD_RLD : ACT_DEC;
              irq_set_o = cnt_zero;
            end
            MD_EVENT: if (evt_in) begin
              act_o     = cnt_zero ? ACT_LD_RLD : ACT_DEC;
              irq_set_o = cnt_zero;
            end
            MD_CAPTURE: begin
              if (trig_rise) begin
                act_o     = ACT_CAP_ZERO;
                irq_set_o = 1'b1;
              end else if (tick_en) begin
                act_o = ACT_INC;
              end
            end
            MD_ONESHOT: if (tick_en) begin
              if (cnt_zero) begin
                irq_set_o = 1'b1;
                state_d   = ST_WAIT;
              end else begin
                act_o = ACT_DEC;
              end
            end
            MD_CAP_ONESHOT: begin
              if (trig_rise) begin
                act_o     = ACT_CAP_HOLD;
                irq_set_o = 1'b1;
                state_d   = ST_WAIT;
              end else if (tick_en) begin
                act_o = ACT_INC;
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      mode_q  <= MD_INTERVAL;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      en_q    <= en_d;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_act_e         act_i,
  input  logic             irq_set_i,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             irq_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q;
  logic             cnt_we, cap_we, irq_q;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_we = 1'b0;
    cap_we = 1'b0;
    case (act_i)
      ACT_LD_RLD:   begin cnt_d = reload_val;  cnt_we = 1'b1; end
      ACT_LD_ZERO:  begin cnt_d = '0;          cnt_we = 1'b1; end
      ACT_DEC:      begin cnt_d = cnt_q - ONE; cnt_we = 1'b1; end
      ACT_INC:      begin cnt_d = cnt_q + ONE; cnt_we = 1'b1; end
      ACT_CAP_ZERO: begin cnt_d = '0; cnt_we = 1'b1; cap_we = 1'b1; end
      ACT_CAP_HOLD: cap_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_we) cnt_q <= cnt_d;
      if (cap_we) cap_q <= cnt_q;
      irq_q <= irq_set_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign cap_o  = cap_q;
  assign irq_o  = irq_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tmr_chan_start.sv
module tmr_chan_start
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             start_wr,
  input  logic             stop_wr,
  input  logic [2:0]       mode_sel,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             evt_in,
  input  logic             trig_in,
  output logic [CNT_W-1:0] cnt_val,
  output logic             chan_en,
  output logic [CNT_W-1:0] cap_val,
  output logic             irq
);
  logic     rst_sync_n, trig_rise, cnt_zero, irq_set;
  tmr_act_e act;

  tmr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tmr_edge_det i_trig_edge (
    .clk(clk), .rst_n(rst_sync_n), .sig_in(trig_in), .rise_o(trig_rise)
  );

  tmr_start_ctl i_ctl (
    .clk(clk), .rst_n(rst_sync_n), .start_wr(start_wr), .stop_wr(stop_wr),
    .mode_sel(mode_sel), .tick_en(tick_en), .evt_in(evt_in),
    .trig_rise(trig_rise), .cnt_zero(cnt_zero), .act_o(act),
    .irq_set_o(irq_set), .en_o(chan_en)
  );

  tmr_count_core #(.CNT_W(CNT_W)) i_core (
    .clk(clk), .rst_n(rst_sync_n), .act_i(act), .irq_set_i(irq_set),
    .reload_val(reload_val), .cnt_o(cnt_val), .cap_o(cap_val),
    .irq_o(irq), .zero_o(cnt_zero)
  );
endmodule

// File: rtl/tmr_chan_start_chk.sv
module tmr_chan_start_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             start_wr,
  input logic             stop_wr,
  input logic [2:0]       mode_sel,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] cnt_val,
  input logic             chan_en,
  input logic             irq
);
  AST_EN_ON_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_wr && !stop_wr |=> chan_en); // R2
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stop_wr |=> !chan_en && $stable(cnt_val)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !chan_en && !start_wr |=> $stable(cnt_val)); // R10
  AST_INTERVAL_WAIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_wr && !stop_wr && mode_sel == 3'd0 |=> $stable(cnt_val)); // R3
  AST_EVENT_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_wr && !stop_wr && mode_sel == 3'd1 |=> cnt_val == $past(reload_val)); // R5
  AST_IRQ_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> $past(chan_en)); // R4
endmodule

bind tmr_chan_start tmr_chan_start_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .start_wr(start_wr), .stop_wr(stop_wr),
  .mode_sel(mode_sel), .reload_val(reload_val), .cnt_val(cnt_val),
  .chan_en(chan_en), .irq(irq)
);

// File: tb/test_tmr_chan_start.sv
module test_tmr_chan_start;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n, tick_en, start_wr, stop_wr, evt_in, trig_in;
  logic [2:0]       mode_sel;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt_val, cap_val;
  logic             chan_en, irq;

  int total = 0;
  int bad   = 0;
  int last  = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  tmr_chan_start #(.CNT_W(CNT_W)) i_tmr_chan_start (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start_wr(start_wr),
    .stop_wr(stop_wr), .mode_sel(mode_sel), .reload_val(reload_val),
    .evt_in(evt_in), .trig_in(trig_in), .cnt_val(cnt_val), .chan_en(chan_en),
    .cap_val(cap_val), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  // drive one cycle of inputs, then sample at the following falling edge
  task automatic step(input logic t, input logic e, input logic g,
                      input logic s, input logic p);
    tick_en = t; evt_in = e; trig_in = g; start_wr = s; stop_wr = p;
    @(posedge clk);
    @(negedge clk);
    tick_en = 0; evt_in = 0; start_wr = 0; stop_wr = 0;
  endtask

  task automatic stop_and_freeze(input string tag);
    step(0, 0, 0, 0, 1);
    chk({tag, " R10 en"}, chan_en, 0);
    chk({tag, " R10 cnt"}, cnt_val, last);
    step(1, 1, 1, 0, 0);
    step(1, 1, 0, 0, 0);
    chk({tag, " R10 frozen"}, cnt_val, last);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick_en = 0; start_wr = 0; stop_wr = 0; evt_in = 0; trig_in = 0;
    mode_sel = 0; reload_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 cnt", cnt_val, 0);
    chk("R1 cap", cap_val, 0);
    chk("R1 en", chan_en, 0);
    chk("R1 irq", irq, 0);

    // interval sweep
    for (int r = 0; r <= 5; r++) begin
      mode_sel = 3'd0; reload_val = CNT_W'(r);
      step(0, 0, 0, 1, 0);
      chk("R2 en after start", chan_en, 1);
      chk("R3 interval hold at start", cnt_val, last);
      step(0, 0, 0, 0, 0);
      chk("R3 interval hold no tick", cnt_val, last);
      step(1, 0, 0, 0, 0);
      chk("R4 first tick load", cnt_val, r);
      chk("R4 no irq on load", irq, 0);
      for (int n = 1; n <= 3 * (r + 1); n++) begin
        if (n == 2) begin
          step(0, 0, 0, 0, 0);
          chk("R4 hold between ticks", cnt_val, r - ((n - 1) % (r + 1)));
        end
        step(1, 0, 0, 0, 0);
        chk("R4 count", cnt_val, r - (n % (r + 1)));
        chk("R4 irq", irq, int'(n % (r + 1) == 0));
      end
      last = r;
      stop_and_freeze("interval");
    end

    // reserved code behaves as interval
    mode_sel = 3'd6; reload_val = 3;
    step(0, 0, 0, 1, 0);
    chk("R2 reserved hold", cnt_val, last);
    step(1, 0, 0, 0, 0);
    chk("R2 reserved load", cnt_val, 3);
    step(1, 0, 0, 0, 0);
    chk("R2 reserved dec", cnt_val, 2);
    last = 2;
    stop_and_freeze("reserved");

    // start and stop in the same cycle: stop wins
    mode_sel = 3'd0; reload_val = 9;
    step(0, 0, 0, 1, 1);
    chk("R2 stop wins en", chan_en, 0);
    step(1, 0, 0, 0, 0);
    chk("R2 stop wins cnt", cnt_val, last);

    // stop cancels a pending start
    mode_sel = 3'd0; reload_val = 7;
    step(0, 0, 0, 1, 0);
    stop_and_freeze("pending");

    // event counter sweep
    for (int r = 1; r <= 4; r++) begin
      mode_sel = 3'd1; reload_val = CNT_W'(r);
      step(0, 0, 0, 1, 0);
      chk("R5 immediate load", cnt_val, r);
      step(1, 0, 0, 0, 0);
      chk("R5 tick ignored", cnt_val, r);
      step(0, 0, 1, 0, 0);
      chk("R5 trigger ignored", cnt_val, r);
      for (int n = 1; n <= 2 * (r + 1); n++) begin
        step(0, 1, 0, 0, 0);
        chk("R5 event count", cnt_val, r - (n % (r + 1)));
        chk("R5 irq", irq, int'(n % (r + 1) == 0));
      end
      last = r;
      stop_and_freeze("event");
    end

    // capture mode
    mode_sel = 3'd2;
    step(0, 0, 0, 1, 0);
    chk("R3 capture hold at start", cnt_val, last);
    step(1, 0, 0, 0, 0);
    chk("R6 first tick zero", cnt_val, 0);
    for (int len = 0; len <= 4; len++) begin
      for (int k = 1; k <= len; k++) begin
        step(1, 0, 0, 0, 0);
        chk("R6 count up", cnt_val, k);
      end
      step(0, 0, 1, 0, 0);
      chk("R6 cap value", cap_val, len);
      chk("R6 cap irq", irq, 1);
      chk("R6 restart zero", cnt_val, 0);
      step(0, 0, 0, 0, 0);
      chk("R6 irq one cycle", irq, 0);
    end
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0);
    chk("R6 trigger beats tick cnt", cnt_val, 0);
    chk("R6 trigger beats tick cap", cap_val, 2);
    step(1, 0, 1, 0, 0);
    chk("R11 held trigger cnt", cnt_val, 1);
    chk("R11 held trigger cap", cap_val, 2);
    chk("R11 held trigger irq", irq, 0);
    step(1, 0, 1, 0, 0);
    chk("R11 held trigger cnt2", cnt_val, 2);
    last = 2;
    stop_and_freeze("capture");

    // one-shot sweep
    for (int r = 0; r <= 3; r++) begin
      mode_sel = 3'd3; reload_val = CNT_W'(r);
      step(0, 0, 0, 1, 0);
      chk("R7 en", chan_en, 1);
      chk("R7 hold at start", cnt_val, last);
      step(1, 0, 0, 0, 0);
      chk("R7 tick ignored while waiting", cnt_val, last);
      step(0, 0, 1, 0, 0);
      chk("R7 trigger no load", cnt_val, last);
      step(0, 0, 0, 0, 0);
      chk("R7 armed hold", cnt_val, last);
      step(1, 0, 0, 0, 0);
      chk("R7 load reload", cnt_val, r);
      for (int n = 1; n <= r; n++) begin
        step(1, 0, n == 1, 0, 0);
        chk("R8 count down, trigger ignored", cnt_val, r - n);
        chk("R8 no early irq", irq, 0);
      end
      step(1, 0, 0, 0, 0);
      chk("R8 end cnt", cnt_val, 0);
      chk("R8 end irq", irq, 1);
      step(1, 0, 0, 0, 0);
      chk("R8 back to waiting", cnt_val, 0);
      chk("R8 single irq", irq, 0);
      step(1, 0, 1, 0, 0);
      chk("R7 same-cycle tick no load", cnt_val, 0);
      step(1, 0, 0, 0, 0);
      chk("R7 rearm load", cnt_val, r);
      last = r;
      stop_and_freeze("oneshot");
    end

    // one-shot capture sweep
    mode_sel = 3'd4;
    step(0, 0, 0, 1, 0);
    chk("R9 hold at start", cnt_val, last);
    for (int len = 1; len <= 4; len++) begin
      step(0, 0, 1, 0, 0);
      step(1, 0, 0, 0, 0);
      chk("R9 load zero", cnt_val, 0);
      for (int k = 1; k <= len; k++) begin
        step(1, 0, 0, 0, 0);
        chk("R9 count up", cnt_val, k);
      end
      step(0, 0, 1, 0, 0);
      chk("R9 cap value", cap_val, len);
      chk("R9 irq", irq, 1);
      chk("R9 counter held", cnt_val, len);
      step(1, 0, 0, 0, 0);
      chk("R9 waiting", cnt_val, len);
    end
    last = 4;
    stop_and_freeze("caponeshot");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule